// File: doc/BRIEF.md
# Legacy Display Address Claim Decoder

This block sits on the upstream side of a PCI-to-PCI bridge and decides, for each memory or I/O access it is shown, whether the bridge must positively claim it and pass it downstream. Two rules can claim an access. The first rule covers the fixed legacy display windows: one memory range and two small I/O ranges. The second rule is the programmable I/O base/limit window. When the legacy display rule applies, it takes priority over the second rule, and it does not depend on the window bounds or on the ISA-style I/O filtering.

The legacy display rule is armed by a single enable bit. This bit is held in a register that clears on reset and is loaded through a one-bit write port. All other inputs come from the surrounding configuration logic and feed purely combinational decoding. The block outputs a claim flag, plus one flag for each rule, so that the rule that fired can be seen. Accesses observed on the downstream bus are never claimed.

Top module: `vga_fwd_decoder`

## Requirements
- R1: After reset the legacy display enable is clear, so no access is claimed through the legacy display rule (`hit_vga` = 0).
- R2: A write (`cfg_wr_en` = 1 at a rising clock edge) loads `cfg_wr_data` into the enable. Decoding uses the new value from that edge onward. Writing 0 disables the rule again.
- R3: With the enable set, `bus_cmd` = 2'b01 (memory) and `mem_space_en` = 1, memory addresses 0x000A0000 through 0x000BFFFF inclusive are claimed with `hit_vga` = 1. Addresses just outside that span are not claimed by this rule.
- R4: With the enable set, `bus_cmd` = 2'b10 (I/O) and `io_space_en` = 1, an I/O address is claimed by the legacy display rule when bits 31:16 are all zero and bits 9:0 lie in 0x3B0..0x3BB or 0x3C0..0x3DF. Bits 15:10 take no part in the comparison.
- R5: The legacy display rule needs `mem_space_en` for memory accesses and `io_space_en` for I/O accesses. When the needed enable is 0, the access is not claimed by that rule.
- R6: When the legacy display rule matches, `hit_vga` = 1 and `hit_window` = 0. This holds whatever the values of `io_base`, `io_limit` and `isa_mode`.
- R7: The window rule claims (`hit_window` = 1) only I/O accesses with `io_space_en` = 1 and `io_base` <= address <= `io_limit`. Both bounds are inclusive.
- R8: With `isa_mode` = 1, the window rule rejects any address whose bits 31:16 are zero and whose bits 9:8 are not 2'b00. With the enable clear, a legacy display I/O address is therefore claimed only through the window rule, and only while `isa_mode` = 0.
- R9: When `bus_secondary` = 1, nothing is claimed: `claim`, `hit_vga` and `hit_window` are all 0.
- R10: `bus_cmd` values 2'b00 (idle) and 2'b11 (reserved) never produce a claim.
- R11: `claim` equals `hit_vga` OR `hit_window`, and the two rule flags are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the legacy display enable |
| cfg_wr_data | input | 1 | Value written to the enable |
| bus_secondary | input | 1 | 1 = access was observed on the downstream bus |
| bus_cmd | input | 2 | 00 idle, 01 memory, 10 I/O, 11 reserved |
| bus_addr | input | 32 | Access address |
| mem_space_en | input | 1 | Memory space enable from the command register |
| io_space_en | input | 1 | I/O space enable from the command register |
| isa_mode | input | 1 | ISA-style I/O window filtering |
| io_base | input | 32 | I/O window lower bound (inclusive) |
| io_limit | input | 32 | I/O window upper bound (inclusive) |
| claim | output | 1 | Claim and forward downstream |
| hit_vga | output | 1 | Claimed by the legacy display rule |
| hit_window | output | 1 | Claimed by the I/O base/limit window rule |

## Verification
The bench builds the block with its default parameters: a 32-bit address, aliased I/O decode that ignores bits 15:10, and ISA filtering compiled in. These defaults make the alias cases reachable, such as 0x7FB0 being claimed while 0x103B0 is refused. They also make reachable the interaction between the ISA filter and a window that covers the display ports. A behavioural model in the bench uses integer arithmetic on offsets modulo 1024. It is compared with the block on every cycle, during both directed edge cases and a long stretch of random traffic that includes enable writes.

// File: rtl/vgadec_pkg.sv
package vgadec_pkg;

  localparam int unsigned PCI_AW = 32;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_MEM  = 2'b01,
    CMD_IO   = 2'b10,
    CMD_RSVD = 2'b11
  } bus_cmd_e;

  // Legacy display memory aperture
  localparam logic [PCI_AW-1:0] DISP_MEM_LO = 32'h000A_0000;
  localparam logic [PCI_AW-1:0] DISP_MEM_HI = 32'h000B_FFFF;

  // Legacy display port spans, compared on the low 10 bits
  localparam int unsigned PORT_BITS = 10;
  localparam logic [PORT_BITS-1:0] MONO_LO  = 10'h3B0;
  localparam logic [PORT_BITS-1:0] MONO_HI  = 10'h3BB;
  localparam logic [PORT_BITS-1:0] COLOR_LO = 10'h3C0;
  localparam logic [PORT_BITS-1:0] COLOR_HI = 10'h3DF;

  function automatic logic addr_in_span(input logic [PCI_AW-1:0] v,
                                        input logic [PCI_AW-1:0] lo,
                                        input logic [PCI_AW-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic port_in_span(input logic [PORT_BITS-1:0] v,
                                        input logic [PORT_BITS-1:0] lo,
                                        input logic [PORT_BITS-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/vga_mem_match.sv
module vga_mem_match
  import vgadec_pkg::*;
(
  input  logic [PCI_AW-1:0] addr,
  output logic              in_aperture
);
  assign in_aperture = addr_in_span(addr, DISP_MEM_LO, DISP_MEM_HI);
endmodule

// File: rtl/vga_io_match.sv
module vga_io_match
  import vgadec_pkg::*;
#(
  parameter int unsigned HI_LSB      = 16,
  parameter bit          CHECK_ALIAS = 1'b0
)(
  input  logic [PCI_AW-1:0] addr,
  output logic              in_ports,
  output logic              upper_zero
);
  localparam int unsigned MID_W = HI_LSB - PORT_BITS;

  logic [PORT_BITS-1:0] port_off;
  logic [MID_W-1:0]     mid_bits;
  logic                 mid_ok;
  logic                 span_ok;

  assign port_off   = addr[PORT_BITS-1:0];
  assign mid_bits   = addr[HI_LSB-1:PORT_BITS];
  assign upper_zero = (addr[PCI_AW-1:HI_LSB] == '0);
  assign mid_ok     = CHECK_ALIAS ? (mid_bits == '0) : 1'b1;
  assign span_ok    = port_in_span(port_off, MONO_LO, MONO_HI) ||
                      port_in_span(port_off, COLOR_LO, COLOR_HI);
  assign in_ports   = upper_zero && mid_ok && span_ok;
endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import vgadec_pkg::*;
#(
  parameter bit          ISA_FILTER = 1'b1,
  parameter int unsigned ISA_TOP    = 16
)(
  input  logic [PCI_AW-1:0] addr,
  input  logic [PCI_AW-1:0] base,
  input  logic [PCI_AW-1:0] limit,
  input  logic              isa_mode,
  output logic              in_window,
  output logic              isa_blocked
);
  logic bounds_ok;

  assign bounds_ok = addr_in_span(addr, base, limit);

  generate
    if (ISA_FILTER) begin : g_isa
      assign isa_blocked = isa_mode && (addr[PCI_AW-1:ISA_TOP] == '0) &&
                           (addr[9:8] != 2'b00);
    end else begin : g_no_isa
      assign isa_blocked = 1'b0;
    end
  endgenerate

  assign in_window = bounds_ok && !isa_blocked;
endmodule

// File: rtl/vga_fwd_decoder.sv
module vga_fwd_decoder
  import vgadec_pkg::*;
#(
  parameter bit          CHECK_ALIAS = 1'b0,
  parameter bit          ISA_FILTER  = 1'b1,
  parameter int unsigned HI_LSB      = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_data,
  input  logic              bus_secondary,
  input  logic [1:0]        bus_cmd,
  input  logic [PCI_AW-1:0] bus_addr,
  input  logic              mem_space_en,
  input  logic              io_space_en,
  input  logic              isa_mode,
  input  logic [PCI_AW-1:0] io_base,
  input  logic [PCI_AW-1:0] io_limit,
  output logic              claim,
  output logic              hit_vga,
  output logic              hit_window
);

  logic disp_en_q;
  logic is_mem, is_io, primary;
  logic mem_ap_hit, io_port_hit, io_upper_zero;
  logic win_hit, win_isa_blocked;
  logic vga_mem_claim, vga_io_claim, win_claim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         disp_en_q <= 1'b0;
    else if (cfg_wr_en) disp_en_q <= cfg_wr_data;
  end

  assign is_mem  = (bus_cmd == CMD_MEM);
  assign is_io   = (bus_cmd == CMD_IO);
  assign primary = !bus_secondary;

  vga_mem_match u_mem (
    .addr        (bus_addr),
    .in_aperture (mem_ap_hit)
  );

  vga_io_match #(
    .HI_LSB      (HI_LSB),
    .CHECK_ALIAS (CHECK_ALIAS)
  ) u_io (
    .addr       (bus_addr),
    .in_ports   (io_port_hit),
    .upper_zero (io_upper_zero)
  );

  iowin_match #(
    .ISA_FILTER (ISA_FILTER),
    .ISA_TOP    (HI_LSB)
  ) u_win (
    .addr        (bus_addr),
    .base        (io_base),
    .limit       (io_limit),
    .isa_mode    (isa_mode),
    .in_window   (win_hit),
    .isa_blocked (win_isa_blocked)
  );

  assign vga_mem_claim = primary && disp_en_q && is_mem && mem_space_en && mem_ap_hit;
  assign vga_io_claim  = primary && disp_en_q && is_io && io_space_en && io_port_hit;
  assign win_claim     = primary && is_io && io_space_en && win_hit;

  assign hit_vga    = vga_mem_claim || vga_io_claim;
  assign hit_window = win_claim && !hit_vga;
  assign claim      = hit_vga || hit_window;

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_vga, hit_window}));

  // R11
  claim_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (hit_vga || hit_window));

  // R9
  sec_noclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_secondary |-> !claim);

  // R10
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_IDLE || bus_cmd == CMD_RSVD) |-> !claim);

  // R5
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vga && bus_cmd == CMD_MEM) |-> mem_space_en);

  // R4
  io_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vga && bus_cmd == CMD_IO) |-> (io_space_en && io_upper_zero));

  // R7
  win_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_window |-> (bus_cmd == CMD_IO && bus_addr >= io_base && bus_addr <= io_limit));

  // R8
  win_isa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_window |-> !win_isa_blocked);

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(disp_en_q));

endmodule

// File: tb/tb_vga_fwd_decoder.sv
module tb_vga_fwd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0, cfg_wr_data = 1'b0;
  logic bus_secondary = 1'b0;
  logic [1:0] bus_cmd = 2'b00;
  logic [31:0] bus_addr = '0;
  logic mem_space_en = 1'b0, io_space_en = 1'b0, isa_mode = 1'b0;
  logic [31:0] io_base = '0, io_limit = '0;
  logic claim, hit_vga, hit_window;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit model_en = 1'b0;
  bit done = 1'b0;

  vga_fwd_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .bus_secondary(bus_secondary), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .mem_space_en(mem_space_en), .io_space_en(io_space_en), .isa_mode(isa_mode),
    .io_base(io_base), .io_limit(io_limit),
    .claim(claim), .hit_vga(hit_vga), .hit_window(hit_window)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of the enable register: updated at each rising edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) model_en <= 1'b0;
    else if (cfg_wr_en) model_en <= cfg_wr_data;
  end

  function automatic bit ref_vga();
    longint unsigned a = longint'(bus_addr);
    int off = int'(a % 1024);
    if (bus_secondary || !model_en) return 1'b0;
    if (bus_cmd == 2'b01)
      return mem_space_en && a >= 655360 && a <= 786431;
    if (bus_cmd == 2'b10)
      return io_space_en && a < 65536 &&
             ((off >= 944 && off <= 955) || (off >= 960 && off <= 991));
    return 1'b0;
  endfunction

  function automatic bit ref_win();
    longint unsigned a = longint'(bus_addr);
    bit isa_reject;
    if (bus_secondary || bus_cmd != 2'b10 || !io_space_en) return 1'b0;
    isa_reject = isa_mode && a < 65536 && (a % 1024) >= 256;
    return a >= longint'(io_base) && a <= longint'(io_limit) && !isa_reject;
  endfunction

  task automatic check(input string tag, input bit exp_claim, input bit exp_vga,
                       input bit exp_win);
    checks++;
    if (claim !== exp_claim || hit_vga !== exp_vga || hit_window !== exp_win) begin
      fails++;
      $display("FAIL %s addr=%h cmd=%b got claim/vga/win=%b%b%b expected=%b%b%b",
               tag, bus_addr, bus_cmd, claim, hit_vga, hit_window,
               exp_claim, exp_vga, exp_win);
    end
  endtask

  task automatic check_model(input string tag);
    bit v = ref_vga();
    bit w = ref_win() && !v;
    check(tag, v || w, v, w);
  endtask

  // Drive at a falling edge, then sample 1 time unit later
  task automatic drive(input bit sec, input logic [1:0] cmd, input logic [31:0] a);
    @(negedge clk);
    bus_secondary = sec; bus_cmd = cmd; bus_addr = a;
    #1;
  endtask

  task automatic write_en(input bit val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    wait (cycles >= MAX_CYCLES || done);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    mem_space_en = 1'b1; io_space_en = 1'b1;
    io_base = 32'h0000_0000; io_limit = 32'h0000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: enable clear after reset
    drive(0, 2'b01, 32'h000A_0000); check("R1", 0, 0, 0);
    drive(0, 2'b10, 32'h0000_03C0); check("R1", 0, 0, 0);

    // R2: write enable, takes effect after the edge
    write_en(1'b1);
    drive(0, 2'b01, 32'h000A_0000); check("R2", 1, 1, 0);

    // R3: memory aperture edges
    drive(0, 2'b01, 32'h000B_FFFF); check("R3", 1, 1, 0);
    drive(0, 2'b01, 32'h0009_FFFF); check("R3", 0, 0, 0);
    drive(0, 2'b01, 32'h000C_0000); check("R3", 0, 0, 0);

    // R4: I/O port spans and aliasing
    drive(0, 2'b10, 32'h0000_03B0); check("R4", 1, 1, 0);
    drive(0, 2'b10, 32'h0000_03BB); check("R4", 1, 1, 0);
    drive(0, 2'b10, 32'h0000_03BC); check("R4", 0, 0, 0);
    drive(0, 2'b10, 32'h0000_03DF); check("R4", 1, 1, 0);
    drive(0, 2'b10, 32'h0000_03E0); check("R4", 0, 0, 0);
    drive(0, 2'b10, 32'h0000_7FB0); check("R4", 1, 1, 0);
    drive(0, 2'b10, 32'h0001_03B0); check("R4", 0, 0, 0);

    // R5: space enables gate the rule
    @(negedge clk) mem_space_en = 1'b0;
    drive(0, 2'b01, 32'h000A_8000); check("R5", 0, 0, 0);
    @(negedge clk) begin mem_space_en = 1'b1; io_space_en = 1'b0; end
    drive(0, 2'b10, 32'h0000_03C4); check("R5", 0, 0, 0);
    @(negedge clk) io_space_en = 1'b1;

    // R6: display rule overrides window and ISA filter
    @(negedge clk) begin io_base = 32'h0000_0000; io_limit = 32'h0000_FFFF; isa_mode = 1'b1; end
    drive(0, 2'b10, 32'h0000_03C0); check("R6", 1, 1, 0);
    @(negedge clk) isa_mode = 1'b0;
    drive(0, 2'b10, 32'h0000_03D5); check("R6", 1, 1, 0);

    // R7: inclusive window bounds
    @(negedge clk) begin io_base = 32'h0000_1000; io_limit = 32'h0000_1FFF; end
    drive(0, 2'b10, 32'h0000_1000); check("R7", 1, 0, 1);
    drive(0, 2'b10, 32'h0000_1FFF); check("R7", 1, 0, 1);
    drive(0, 2'b10, 32'h0000_2000); check("R7", 0, 0, 0);
    drive(0, 2'b10, 32'h0000_0FFF); check("R7", 0, 0, 0);
    drive(0, 2'b01, 32'h0000_1800); check("R7", 0, 0, 0);

    // R8: ISA filter on the window
    @(negedge clk) isa_mode = 1'b1;
    drive(0, 2'b10, 32'h0000_10FF); check("R8", 1, 0, 1);
    drive(0, 2'b10, 32'h0000_1100); check("R8", 0, 0, 0);
    write_en(1'b0);
    @(negedge clk) begin io_base = 32'h0000_0000; io_limit = 32'h0000_0FFF; end
    drive(0, 2'b10, 32'h0000_03C0); check("R8", 0, 0, 0);
    @(negedge clk) isa_mode = 1'b0;
    drive(0, 2'b10, 32'h0000_03C0); check("R8", 1, 0, 1);
    // R2: write of 0 disabled the display rule
    drive(0, 2'b01, 32'h000A_0000); check("R2", 0, 0, 0);

    // R9: downstream accesses never claimed
    write_en(1'b1);
    drive(1, 2'b01, 32'h000A_0000); check("R9", 0, 0, 0);
    drive(1, 2'b10, 32'h0000_03C0); check("R9", 0, 0, 0);

    // R10: idle and reserved commands
    drive(0, 2'b00, 32'h000A_0000); check("R10", 0, 0, 0);
    drive(0, 2'b11, 32'h0000_03C0); check("R10", 0, 0, 0);

    // R11: random traffic compared with the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cfg_wr_en     = ($urandom_range(0, 15) == 0);
      cfg_wr_data   = $urandom_range(0, 3) != 0;
      bus_secondary = ($urandom_range(0, 7) == 0);
      bus_cmd       = 2'($urandom_range(0, 3));
      mem_space_en  = $urandom_range(0, 7) != 0;
      io_space_en   = $urandom_range(0, 7) != 0;
      isa_mode      = $urandom_range(0, 1) == 1;
      io_base       = {16'h0, 16'($urandom_range(0, 16'hFFFF))};
      io_limit      = io_base + 32'($urandom_range(0, 16'h1000));
      case ($urandom_range(0, 3))
        0: bus_addr = 32'h000A_0000 + 32'($urandom_range(0, 32'h2_0000)) - 32'h10;
        1: bus_addr = {($urandom_range(0, 7) == 0) ? 16'h0001 : 16'h0000,
                       6'($urandom), 10'($urandom_range(32'h3A0, 32'h3EF))};
        2: bus_addr = io_base + 32'($urandom_range(0, 16'h1010)) - 32'h8;
        default: bus_addr = $urandom;
      endcase
      #1;
      check_model("R11");
    end
    @(negedge clk) cfg_wr_en = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule